// File: doc/BRIEF.md
# Prefix-Match Address Router

This block connects one requestor to four completers that share a 6-bit requestor address space. The windows in this space have two sizes. Each request carries an address, a length and write/read flags, and it is accepted through a valid/ready handshake. The router compares the upper address bits of each request against a fixed prefix for each completer. It registers the request and then presents it to exactly one completer. On the way it strips the matched prefix, so the completer sees only its local offset, which is 3 or 4 bits wide.

The router handles one transaction at a time. The completer accepts the forwarded command with its ready bit. Later it returns data and an error flag on its own response lines. The router registers that response and returns it to the requestor as a single-cycle pulse. A request whose address falls outside every window is never forwarded. The router answers it with an error response in the cycle after acceptance.

Top module: `addr_router`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0 and cmp_valid_o is 0.
- R2: An accepted request is routed by prefix equality as follows. Addresses 0x00–0x07 go to completer 0 (cmp_valid_o bit 0) and 0x08–0x0F go to completer 1 (bit 1); these two compare address bits 5:3. Addresses 0x10–0x1F go to completer 2 (bit 2) and 0x20–0x2F go to completer 3 (bit 3); these two compare bits 5:4. Where prefixes of different lengths both match, the longer one wins.
- R3: cmp_valid_o never has more than one bit set.
- R4: A request accepted at one clock edge appears on the completer side no earlier than the following cycle. In the cycle of acceptance, cmp_valid_o is 0.
- R5: cmp_addr_o carries the request address with the prefix removed. For completers 0 and 1 this is address bits 2:0 with bit 3 of cmp_addr_o at 0. For completers 2 and 3 it is bits 3:0. cmp_len_o, cmp_wr_o and cmp_rd_o copy the request unchanged.
- R6: A request to 0x30–0x3F raises no cmp_valid_o bit. In the cycle after acceptance it produces rsp_valid_o=1, rsp_err_o=1 and rsp_data_o=0.
- R7: While the selected completer's ready bit is 0, cmp_valid_o and the forwarded fields hold their values.
- R8: When the selected completer raises its response-valid bit, the router drives rsp_valid_o for exactly one cycle, starting in the next cycle. In that cycle rsp_data_o and rsp_err_o carry that completer's data and error values.
- R9: A response-valid bit from a completer that is not selected has no effect.
- R10: req_ready_o is 0 from acceptance until the cycle after the response pulse. A request offered during that time is neither accepted nor forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Requestor command valid |
| req_ready_o | output | 1 | Router can accept a command |
| req_addr_i | input | 6 | Requestor address |
| req_len_i | input | 4 | Transfer length |
| req_wr_i | input | 1 | Write flag |
| req_rd_i | input | 1 | Read flag |
| rsp_valid_o | output | 1 | Response pulse to requestor |
| rsp_err_o | output | 1 | Response error |
| rsp_data_o | output | 8 | Response data |
| cmp_valid_o | output | 4 | Per-completer command valid |
| cmp_ready_i | input | 4 | Per-completer command ready |
| cmp_addr_o | output | 4 | Local completer address |
| cmp_len_o | output | 4 | Forwarded length |
| cmp_wr_o | output | 1 | Forwarded write flag |
| cmp_rd_o | output | 1 | Forwarded read flag |
| cmp_rsp_valid_i | input | 4 | Per-completer response valid |
| cmp_rsp_err_i | input | 4 | Per-completer response error |
| cmp_rsp_data_i | input | 32 | Per-completer response data, 8 bits each, completer 0 in the low byte |

## Verification
The cases hardest to reach from the ports are those where traffic shows up while the router is busy: a second request offered mid-transaction, and a response from a completer that was not selected. The stimulus walks all 64 addresses. For each mapped one it holds the completer's ready low for a varying number of cycles and offers a stray request during the forward phase. It then fires a response on a neighbouring completer before the real one. The bench checks that the output pulse, the data and the next idle state reflect only the selected completer.

// File: rtl/addr_router_pkg.sv
package addr_router_pkg;
  localparam int unsigned AW    = 6;
  localparam int unsigned N_CMP = 4;
  localparam int unsigned LAW   = 4;
  localparam int unsigned LEN_W = 4;
  localparam int unsigned DW    = 8;

  // local width per completer; prefix length = AW - width
  localparam int unsigned    CMP_LW   [N_CMP] = '{3, 3, 4, 4};
  localparam logic [AW-1:0]  CMP_BASE [N_CMP] = '{6'h00, 6'h08, 6'h10, 6'h20};

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FWD,
    ST_WAIT,
    ST_RSP
  } rtr_state_e;

  typedef struct packed {
    logic [LAW-1:0]   addr;
    logic [LEN_W-1:0] len;
    logic             wr;
    logic             rd;
  } cmp_cmd_t;
endpackage

// File: rtl/addr_decode.sv
module addr_decode
  import addr_router_pkg::*;
#(
  parameter int unsigned N   = N_CMP,
  parameter int unsigned A_W = AW,
  parameter int unsigned L_W = LAW
) (
  input  logic [A_W-1:0] addr_i,
  output logic [N-1:0]   sel_o,
  output logic           hit_o,
  output logic [L_W-1:0] local_o
);
  logic [N-1:0] raw;

  for (genvar g = 0; g < N; g++) begin : g_win
    localparam int unsigned LW = CMP_LW[g];
    assign raw[g] = (addr_i[A_W-1:LW] == CMP_BASE[g][A_W-1:LW]);
  end

  // longest prefix wins: drop a match if a longer prefix also matched
  always_comb begin
    for (int i = 0; i < int'(N); i++) begin
      sel_o[i] = raw[i];
      for (int j = 0; j < int'(N); j++) begin
        if (j != i && raw[j] && CMP_LW[j] < CMP_LW[i]) sel_o[i] = 1'b0;
      end
    end
  end

  assign hit_o = |sel_o;

  always_comb begin
    local_o = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (sel_o[i]) local_o = local_o | (addr_i[L_W-1:0] & L_W'((1 << CMP_LW[i]) - 1));
    end
  end
endmodule

// File: rtl/rsp_mux.sv
module rsp_mux #(
  parameter int unsigned N   = 4,
  parameter int unsigned D_W = 8
) (
  input  logic [N-1:0]     sel_i,
  input  logic [N-1:0]     valid_i,
  input  logic [N-1:0]     err_i,
  input  logic [N*D_W-1:0] data_i,
  output logic             fire_o,
  output logic             err_o,
  output logic [D_W-1:0]   data_o
);
  always_comb begin
    fire_o = 1'b0;
    err_o  = 1'b0;
    data_o = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (sel_i[i]) begin
        fire_o = valid_i[i];
        err_o  = err_i[i];
        data_o = data_i[i*D_W +: D_W];
      end
    end
  end
endmodule

// File: rtl/router_ctrl.sv
module router_ctrl
  import addr_router_pkg::*;
#(
  parameter int unsigned N   = N_CMP,
  parameter int unsigned D_W = DW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           req_valid_i,
  output logic           req_ready_o,
  input  logic           hit_i,
  input  logic [N-1:0]   sel_i,
  input  cmp_cmd_t       cmd_i,
  output logic [N-1:0]   cmp_valid_o,
  input  logic [N-1:0]   cmp_ready_i,
  output cmp_cmd_t       cmd_o,
  output logic [N-1:0]   cur_sel_o,
  input  logic           fire_i,
  input  logic           err_i,
  input  logic [D_W-1:0] data_i,
  output logic           rsp_valid_o,
  output logic           rsp_err_o,
  output logic [D_W-1:0] rsp_data_o
);
  rtr_state_e     state_q;
  logic [N-1:0]   sel_q;
  cmp_cmd_t       cmd_q;
  logic           err_q;
  logic [D_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      cmd_q   <= '0;
      err_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          sel_q <= sel_i;
          cmd_q <= cmd_i;
          if (hit_i) begin
            state_q <= ST_FWD;
          end else begin
            err_q   <= 1'b1;
            data_q  <= '0;
            state_q <= ST_RSP;
          end
        end
        ST_FWD:  if (|(sel_q & cmp_ready_i)) state_q <= ST_WAIT;
        ST_WAIT: if (fire_i) begin
          err_q   <= err_i;
          data_q  <= data_i;
          state_q <= ST_RSP;
        end
        ST_RSP:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign cmp_valid_o = (state_q == ST_FWD) ? sel_q : '0;
  assign cmd_o       = cmd_q;
  assign cur_sel_o   = (state_q == ST_WAIT) ? sel_q : '0;
  assign rsp_valid_o = (state_q == ST_RSP);
  assign rsp_err_o   = rsp_valid_o & err_q;
  assign rsp_data_o  = rsp_valid_o ? data_q : '0;
endmodule

// File: rtl/addr_router.sv
module addr_router
  import addr_router_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [AW-1:0]      req_addr_i,
  input  logic [LEN_W-1:0]   req_len_i,
  input  logic               req_wr_i,
  input  logic               req_rd_i,
  output logic               rsp_valid_o,
  output logic               rsp_err_o,
  output logic [DW-1:0]      rsp_data_o,
  output logic [N_CMP-1:0]   cmp_valid_o,
  input  logic [N_CMP-1:0]   cmp_ready_i,
  output logic [LAW-1:0]     cmp_addr_o,
  output logic [LEN_W-1:0]   cmp_len_o,
  output logic               cmp_wr_o,
  output logic               cmp_rd_o,
  input  logic [N_CMP-1:0]   cmp_rsp_valid_i,
  input  logic [N_CMP-1:0]   cmp_rsp_err_i,
  input  logic [N_CMP*DW-1:0] cmp_rsp_data_i
);
  logic [N_CMP-1:0] dec_sel;
  logic             dec_hit;
  logic [LAW-1:0]   dec_local;
  logic [N_CMP-1:0] cur_sel;
  logic             mux_fire;
  logic             mux_err;
  logic [DW-1:0]    mux_data;
  cmp_cmd_t         cmd_in;
  cmp_cmd_t         cmd_out;

  addr_decode #(.N(N_CMP), .A_W(AW), .L_W(LAW)) u_dec (
    .addr_i  (req_addr_i),
    .sel_o   (dec_sel),
    .hit_o   (dec_hit),
    .local_o (dec_local)
  );

  assign cmd_in = '{addr: dec_local, len: req_len_i, wr: req_wr_i, rd: req_rd_i};

  router_ctrl #(.N(N_CMP), .D_W(DW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .hit_i       (dec_hit),
    .sel_i       (dec_sel),
    .cmd_i       (cmd_in),
    .cmp_valid_o (cmp_valid_o),
    .cmp_ready_i (cmp_ready_i),
    .cmd_o       (cmd_out),
    .cur_sel_o   (cur_sel),
    .fire_i      (mux_fire),
    .err_i       (mux_err),
    .data_i      (mux_data),
    .rsp_valid_o (rsp_valid_o),
    .rsp_err_o   (rsp_err_o),
    .rsp_data_o  (rsp_data_o)
  );

  rsp_mux #(.N(N_CMP), .D_W(DW)) u_mux (
    .sel_i   (cur_sel),
    .valid_i (cmp_rsp_valid_i),
    .err_i   (cmp_rsp_err_i),
    .data_i  (cmp_rsp_data_i),
    .fire_o  (mux_fire),
    .err_o   (mux_err),
    .data_o  (mux_data)
  );

  assign cmp_addr_o = cmd_out.addr;
  assign cmp_len_o  = cmd_out.len;
  assign cmp_wr_o   = cmd_out.wr;
  assign cmp_rd_o   = cmd_out.rd;
endmodule

// File: rtl/addr_router_chk.sv
module addr_router_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic [5:0] req_addr_i,
  input logic       rsp_valid_o,
  input logic       rsp_err_o,
  input logic [3:0] cmp_valid_o,
  input logic [3:0] cmp_ready_i,
  input logic [3:0] cmp_addr_o,
  input logic [3:0] dec_sel
);
  a_r3_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dec_sel) && $onehot0(cmp_valid_o));

  a_r4_no_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |-> (cmp_valid_o == 4'b0));

  a_r2_low_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_addr_i[5:3] == 3'b000) |=> (cmp_valid_o == 4'b0001));

  a_r6_unmapped_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_addr_i[5:4] == 2'b11)
      |=> (rsp_valid_o && rsp_err_o && cmp_valid_o == 4'b0));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(cmp_valid_o & ~cmp_ready_i)) |=> ($stable(cmp_valid_o) && $stable(cmp_addr_o)));

  a_r5_narrow_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_valid_o[0] || cmp_valid_o[1]) |-> (cmp_addr_o[3] == 1'b0));

  a_r10_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o || cmp_valid_o != 4'b0) |-> !req_ready_o);
endmodule

bind addr_router addr_router_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_addr_i  (req_addr_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_err_o   (rsp_err_o),
  .cmp_valid_o (cmp_valid_o),
  .cmp_ready_i (cmp_ready_i),
  .cmp_addr_o  (cmp_addr_o),
  .dec_sel     (dec_sel)
);

// File: tb/sim_addr_router.sv
module sim_addr_router;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [5:0]  req_addr_i = '0;
  logic [3:0]  req_len_i = '0;
  logic        req_wr_i = 1'b0;
  logic        req_rd_i = 1'b0;
  logic        rsp_valid_o;
  logic        rsp_err_o;
  logic [7:0]  rsp_data_o;
  logic [3:0]  cmp_valid_o;
  logic [3:0]  cmp_ready_i = '0;
  logic [3:0]  cmp_addr_o;
  logic [3:0]  cmp_len_o;
  logic        cmp_wr_o;
  logic        cmp_rd_o;
  logic [3:0]  cmp_rsp_valid_i = '0;
  logic [3:0]  cmp_rsp_err_i = '0;
  logic [31:0] cmp_rsp_data_i = '0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  addr_router u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic [5:0] a, input int stall, input logic wr);
    int idx;
    logic [3:0] loc;
    logic [3:0] oh;
    logic [7:0] d;
    logic e;
    idx = (a < 6'h08) ? 0 : (a < 6'h10) ? 1 : (a < 6'h20) ? 2 : (a < 6'h30) ? 3 : -1;
    loc = (idx < 2) ? {1'b0, a[2:0]} : a[3:0];
    oh  = (idx >= 0) ? 4'(1 << idx) : 4'b0;
    @(negedge clk_i);
    chk("R10 ready idle", req_ready_o, 1);
    req_valid_i = 1'b1; req_addr_i = a; req_len_i = a[3:0] ^ 4'h5;
    req_wr_i = wr; req_rd_i = ~wr;
    chk("R4 no same-cycle forward", cmp_valid_o, 0);
    @(negedge clk_i);
    if (idx < 0) begin
      req_valid_i = 1'b0;
      chk("R6 no forward", cmp_valid_o, 0);
      chk("R6 rsp valid", rsp_valid_o, 1);
      chk("R6 rsp err", rsp_err_o, 1);
      chk("R6 rsp data", rsp_data_o, 0);
      @(negedge clk_i);
      chk("R10 idle after err", {req_ready_o, rsp_valid_o}, 2'b10);
      return;
    end
    chk("R2 select", cmp_valid_o, oh);
    chk("R3 one select", $countones(cmp_valid_o), 1);
    chk("R5 local addr", cmp_addr_o, loc);
    chk("R5 len/wr/rd", {cmp_len_o, cmp_wr_o, cmp_rd_o}, {a[3:0] ^ 4'h5, wr, ~wr});
    chk("R10 busy", req_ready_o, 0);
    req_addr_i = a ^ 6'h3F; req_wr_i = ~wr; req_rd_i = wr;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk_i);
      chk("R7 hold valid", cmp_valid_o, oh);
      chk("R7 hold addr", cmp_addr_o, loc);
    end
    cmp_ready_i = 4'hF;
    @(negedge clk_i);
    cmp_ready_i = 4'h0; req_valid_i = 1'b0;
    chk("R7 released", cmp_valid_o, 0);
    cmp_rsp_valid_i[(idx + 1) % 4] = 1'b1;
    cmp_rsp_err_i = 4'hF;
    cmp_rsp_data_i = 32'hEEEE_EEEE;
    @(negedge clk_i);
    chk("R9 stray response ignored", rsp_valid_o, 0);
    d = {2'(idx), a};
    e = (a[2:0] == 3'd5);
    cmp_rsp_valid_i = oh;
    cmp_rsp_err_i = e ? oh : 4'h0;
    cmp_rsp_data_i = 32'hEEEE_EEEE;
    cmp_rsp_data_i[idx*8 +: 8] = d;
    @(negedge clk_i);
    cmp_rsp_valid_i = '0; cmp_rsp_err_i = '0; cmp_rsp_data_i = '0;
    chk("R8 rsp valid", rsp_valid_o, 1);
    chk("R8 rsp data", rsp_data_o, d);
    chk("R8 rsp err", rsp_err_o, e);
    @(negedge clk_i);
    chk("R8 single pulse", rsp_valid_o, 0);
    chk("R10 stray request dropped", {req_ready_o, cmp_valid_o}, 5'b10000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    chk("R1 reset ready", req_ready_o, 1);
    chk("R1 reset rsp", rsp_valid_o, 0);
    chk("R1 reset cmp", cmp_valid_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int a = 0; a < 64; a++) run_txn(6'(a), a % 3, a[0]);
    run_txn(6'h3F, 0, 1'b1);
    run_txn(6'h07, 2, 1'b0);
    run_txn(6'h08, 0, 1'b1);
    run_txn(6'h2F, 1, 1'b0);
    run_txn(6'h30, 0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule